// File: doc/BRIEF.md
# Dual-Port Counting Register Bank

This block holds four 16-bit general purpose registers for a small word-oriented processor. Each register is a loadable up/down counter. A register can be written from the incoming data word, or stepped by one in either direction where it sits, within a single clock and without passing through an arithmetic unit. Register indices 0, 1, 2 and 3 correspond to the processor's B, C, D and E registers.

Two read paths run side by side. One feeds the data bus and one feeds the address bus. Each path has its own select and its own enable, so one register can supply a pointer for an indirect memory access while another supplies a data word in the same cycle. Both read paths are combinational and show the register contents as they stand before the clock edge that ends the cycle.

All data moves in a single cycle. There is no valid/ready handshake and no back-pressure. A write strobe is always accepted at the next rising edge, and a read path is valid whenever its enable is high.

Top module: `dual_bus_regbank`

## Requirements
- R1: While `rst_n` is low, every register is forced to 0x0000. After reset, both read paths return 0x0000 for every register until a register is written.
- R2: When `ld_en` is high, the register chosen by `wr_sel` (0 to 3) takes the value of `wr_data` at the next rising edge.
- R3: When `inc_en` is high and both `ld_en` and `dec_en` are low, the chosen register increases by one at the next edge. It wraps from 0xFFFF to 0x0000.
- R4: When `dec_en` is high and both `ld_en` and `inc_en` are low, the chosen register decreases by one at the next edge. It wraps from 0x0000 to 0xFFFF.
- R5: When `ld_en` is high, the load takes effect and any increment or decrement request in the same cycle is ignored.
- R6: When `inc_en` and `dec_en` are both high and `ld_en` is low, the chosen register keeps its value.
- R7: When none of the three strobes is high, no register changes.
- R8: When `dbus_oe` is high, `dbus_q` shows the register chosen by `dbus_sel`, using its value before this cycle's update. When `dbus_oe` is low, `dbus_q` is 0x0000.
- R9: `abus_q` follows the same rule as R8, using `abus_oe` and `abus_sel`. This path is independent of the data path, so the two paths may show different registers, or the same register, in the same cycle.
- R10: A write operation changes only the register chosen by `wr_sel`. The other registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all updates occur on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_sel | input | 2 | Index of the register to be written or stepped |
| ld_en | input | 1 | Load `wr_data` into the chosen register |
| inc_en | input | 1 | Add one to the chosen register |
| dec_en | input | 1 | Subtract one from the chosen register |
| wr_data | input | 16 | Word taken from the data bus |
| dbus_oe | input | 1 | Enable for the data-bus read path |
| dbus_sel | input | 2 | Register shown on the data-bus path |
| dbus_q | output | 16 | Data-bus read value |
| abus_oe | input | 1 | Enable for the address-bus read path |
| abus_sel | input | 2 | Register shown on the address-bus path |
| abus_q | output | 16 | Address-bus read value |

## Verification
Both read paths have zero latency. Their results are due in the same cycle as the select and enable inputs. A write or count request shows up one rising edge later, on a read path that selects the same register. The bench drives inputs just after the falling edge and samples both outputs one nanosecond later, before the rising edge. It compares these samples against a behavioural model that has not yet applied the pending operation. It advances the model only after the rising edge, so every effect of a write is checked in the cycle after the write.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  localparam int unsigned GPR_W = 16;
  localparam int unsigned GPR_N = 4;

  typedef enum logic [1:0] {
    CELL_HOLD = 2'd0,
    CELL_UP   = 2'd1,
    CELL_DOWN = 2'd2,
    CELL_LOAD = 2'd3
  } cell_op_e;

endpackage

// File: rtl/gpr_wdec.sv
module gpr_wdec
  import regbank_pkg::*;
#(
  parameter int unsigned N  = GPR_N,
  parameter int unsigned SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SW-1:0]     wr_sel,
  input  logic              ld_en,
  input  logic              inc_en,
  input  logic              dec_en,
  output cell_op_e [N-1:0]  ops
);

  cell_op_e req_op;

  // Load outranks counting; opposing count requests cancel.
  always_comb begin
    if (ld_en)                 req_op = CELL_LOAD;
    else if (inc_en && !dec_en) req_op = CELL_UP;
    else if (dec_en && !inc_en) req_op = CELL_DOWN;
    else                       req_op = CELL_HOLD;
  end

  for (genvar i = 0; i < N; i++) begin : g_dec
    always_comb begin
      ops[i] = (wr_sel == SW'(i)) ? req_op : CELL_HOLD;
    end

    // R10: unselected cell never receives an operation
    a_r10_only_target: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sel != SW'(i)) |-> (ops[i] == CELL_HOLD));
  end

  // R5: load strobe always reaches the addressed cell as a load
  a_r5_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |-> (ops[wr_sel] == CELL_LOAD));

endmodule

// File: rtl/gpr_cell.sv
module gpr_cell
  import regbank_pkg::*;
#(
  parameter int unsigned W = GPR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  cell_op_e     op,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      unique case (op)
        CELL_LOAD: q <= din;
        CELL_UP:   q <= q + W'(1);
        CELL_DOWN: q <= q - W'(1);
        default:   q <= q;
      endcase
    end
  end

  a_r3_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (op == CELL_UP) |=> (q == $past(q) + W'(1)));

  a_r4_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (op == CELL_DOWN) |=> (q == $past(q) - W'(1)));

  a_r2_preset: assert property (@(posedge clk) disable iff (!rst_n)
    (op == CELL_LOAD) |=> (q == $past(din)));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (op == CELL_HOLD) |=> $stable(q));

endmodule

// File: rtl/gpr_rdport.sv
module gpr_rdport
  import regbank_pkg::*;
#(
  parameter int unsigned N  = GPR_N,
  parameter int unsigned W  = GPR_W,
  parameter int unsigned SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0][W-1:0] regs,
  input  logic                oe,
  input  logic [SW-1:0]       sel,
  output logic [W-1:0]        q
);

  always_comb begin
    q = '0;
    if (oe) begin
      for (int i = 0; i < N; i++) begin
        if (sel == SW'(i)) q = regs[i];
      end
    end
  end

endmodule

// File: rtl/dual_bus_regbank.sv
module dual_bus_regbank
  import regbank_pkg::*;
#(
  parameter int unsigned W  = GPR_W,
  parameter int unsigned N  = GPR_N,
  parameter int unsigned SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] wr_sel,
  input  logic          ld_en,
  input  logic          inc_en,
  input  logic          dec_en,
  input  logic [W-1:0]  wr_data,
  input  logic          dbus_oe,
  input  logic [SW-1:0] dbus_sel,
  output logic [W-1:0]  dbus_q,
  input  logic          abus_oe,
  input  logic [SW-1:0] abus_sel,
  output logic [W-1:0]  abus_q
);

  cell_op_e [N-1:0]    ops;
  logic [N-1:0][W-1:0] regs;

  gpr_wdec #(.N(N), .SW(SW)) u_wdec (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_sel (wr_sel),
    .ld_en  (ld_en),
    .inc_en (inc_en),
    .dec_en (dec_en),
    .ops    (ops)
  );

  for (genvar i = 0; i < N; i++) begin : g_cell
    gpr_cell #(.W(W)) u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .op    (ops[i]),
      .din   (wr_data),
      .q     (regs[i])
    );
  end

  gpr_rdport #(.N(N), .W(W), .SW(SW)) u_dport (
    .regs (regs),
    .oe   (dbus_oe),
    .sel  (dbus_sel),
    .q    (dbus_q)
  );

  gpr_rdport #(.N(N), .W(W), .SW(SW)) u_aport (
    .regs (regs),
    .oe   (abus_oe),
    .sel  (abus_sel),
    .q    (abus_q)
  );

  // R9: two paths on the same register agree
  a_r9_paths_agree: assert property (@(posedge clk) disable iff (!rst_n)
    (dbus_oe && abus_oe && dbus_sel == abus_sel) |-> (dbus_q == abus_q));

  // R8: disabled data path is quiet
  a_r8_dbus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !dbus_oe |-> (dbus_q == '0));

  // R1: first cycle after reset every register reads zero
  a_r1_reset_zero: assert property (@(posedge clk)
    !rst_n |=> (regs == '0));

endmodule

// File: tb/dual_bus_regbank_tb.sv
`timescale 1ns/1ps
module dual_bus_regbank_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic        ld_en = 1'b0, inc_en = 1'b0, dec_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        dbus_oe = 1'b0, abus_oe = 1'b0;
  logic [1:0]  dbus_sel = '0, abus_sel = '0;
  logic [15:0] dbus_q, abus_q;

  int unsigned model [4];
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dual_bus_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .ld_en(ld_en),
    .inc_en(inc_en), .dec_en(dec_en), .wr_data(wr_data),
    .dbus_oe(dbus_oe), .dbus_sel(dbus_sel), .dbus_q(dbus_q),
    .abus_oe(abus_oe), .abus_sel(abus_sel), .abus_q(abus_q)
  );

  task automatic chk(input string tag, input string what,
                     input logic [15:0] got, input logic [15:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // Drive after the falling edge, check before the rising edge, then advance the model.
  task automatic step(input string tag, input bit ld, input bit inc, input bit dec,
                      input logic [1:0] ws, input logic [15:0] wd,
                      input bit doe, input logic [1:0] ds,
                      input bit aoe, input logic [1:0] as_);
    ld_en = ld; inc_en = inc; dec_en = dec; wr_sel = ws; wr_data = wd;
    dbus_oe = doe; dbus_sel = ds; abus_oe = aoe; abus_sel = as_;
    #1;
    chk(tag, "dbus_q", dbus_q, doe ? 16'(model[ds]) : 16'h0000);
    chk(tag, "abus_q", abus_q, aoe ? 16'(model[as_]) : 16'h0000);
    @(posedge clk);
    if (ld)              model[ws] = wd;
    else if (inc && !dec) model[ws] = (model[ws] + 1) & 32'hFFFF;
    else if (dec && !inc) model[ws] = (model[ws] + 32'hFFFF) & 32'hFFFF;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) model[i] = 0;
    // R1: pulse a load during reset; it must be overridden
    ld_en = 1'b1; wr_data = 16'hBEEF;
    repeat (3) @(posedge clk);
    ld_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    step("R1", 0,0,0, 0, 0, 1, 0, 1, 3);
    step("R1", 0,0,0, 0, 0, 1, 1, 1, 2);
    // R8: load is not visible until the next edge
    step("R8", 1,0,0, 1, 16'hFFFF, 1, 1, 1, 1);
    // R2: loaded value visible; R3: increment from FFFF wraps
    step("R2", 0,1,0, 1, 0, 1, 1, 1, 1);
    step("R3", 0,0,0, 0, 0, 1, 1, 1, 0);
    // R4: decrement from zero wraps; R10: neighbours untouched
    step("R10", 0,0,1, 2, 0, 1, 2, 1, 3);
    step("R4", 0,0,0, 0, 0, 1, 2, 1, 1);
    // R5: load beats increment and decrement
    step("R5", 1,1,0, 0, 16'h1234, 1, 0, 0, 0);
    step("R5", 1,0,1, 3, 16'h00A5, 1, 0, 1, 3);
    step("R5", 0,0,0, 0, 0, 1, 0, 1, 3);
    // R6: opposing counts cancel
    step("R6", 0,1,1, 0, 0, 1, 0, 0, 0);
    step("R6", 0,0,0, 0, 0, 1, 0, 1, 0);
    // R8/R9: disabled paths quiet, enabled paths independent
    step("R8", 0,0,0, 0, 0, 0, 2, 0, 1);
    step("R9", 0,0,0, 0, 0, 1, 3, 1, 0);
    step("R9", 0,0,0, 0, 0, 0, 3, 1, 2);
    // R7: no strobes, values stable across cycles
    for (int k = 0; k < 4; k++) step("R7", 0,0,0, 2'(k), 16'hFFFF, 1, 2'(k), 1, 2'(3-k));
    // R10: mixed traffic against the model
    for (int k = 0; k < 600; k++) begin
      int unsigned r = $urandom;
      step("R10", r[0] & r[1], r[2], r[3], 2'(r[5:4]), 16'(r[31:16] ^ (k == 7 ? 16'hFFFF : 16'h0)),
           r[6] | r[7], 2'(r[9:8]), r[10] | r[11], 2'(r[13:12]));
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule